// File: doc/BRIEF.md
# Folded Word Memory with Row Decode and Column Selection

This block is a synchronous single-port memory that presents 2048 words of 16 bits to its user. Inside, the words are not kept one per row. They are packed into a folded physical array of 256 rows, and each row is 128 bits wide, so every row carries eight words. Folding turns a long, narrow array into a squarer one, which suits a store whose word count is far larger than its word width.

Every access follows the same path. The upper address field is decoded into a one-hot wordline, and that wordline picks one wide row. The lower address field then drives sixteen 8-way column selectors, and these pull the addressed word out of the row. The bits of each word are interleaved across the row: bit i of the word in column group c lives in physical column 8*i + c.

A write replaces only the sixteen columns of the addressed word, and the rest of the row is written back unchanged. Read data is registered. On a write cycle the register captures the word's contents from before the write. The decoded wordline vector is also brought out to a port, so that the decoder can be observed directly.

Top module: `fold_mem_array`

## Requirements
- R1: While `rst_n` is low, `rd_data` is 0.
- R2: Each of the 2048 word addresses, from 0 through 2047, keeps its own 16-bit value independently of every other address.
- R3: For any address, `wordline` has exactly one bit set.
- R4: The bit set in `wordline` is the one whose index equals `addr[10:3]`.
- R5: After the clock edge that samples an address, `rd_data` shows the word stored there. A write to an address followed on the next cycle by a read of that address returns the written value.
- R6: On a cycle with `wr_en` high, `rd_data` after the edge shows the word's contents from before that write.
- R7: A write changes only the word selected by `addr[2:0]`. The other seven words in the same row keep their values.
- R8: A write to one row leaves the word in the same column group of the neighbouring rows unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the read data register |
| addr | input | 11 | Word address; [10:3] selects the row, [2:0] selects the column group |
| wr_en | input | 1 | High to write `wr_data` to `addr` on this edge |
| wr_data | input | 16 | Data to write |
| rd_data | output | 16 | Registered read data, valid one clock after the address |
| wordline | output | 256 | One-hot decoded row select, for observation |

## Verification
A decoder fault shows on `wordline` in the same cycle that the address is applied: either a bit count other than one, or the wrong bit set. A fault in column selection or interleaving shows one cycle after a read, as a word that carries bits from a neighbouring column group. A fault in the write merge stays hidden until a later read of another word in the same row, which then returns corrupted bits. For that reason the stimulus writes a word and then reads back all eight words of its row and the matching words in the rows on either side.

// File: rtl/fold_mem_pkg.sv
package fold_mem_pkg;
    // Default geometry of the folded array.
    parameter int FM_ADDR_W = 11;  // word address width
    parameter int FM_DATA_W = 16;  // word width
    parameter int FM_COL_W  = 3;   // column-group select width
endpackage

// File: rtl/fold_row_decoder.sv
module fold_row_decoder #(
    parameter int ROW_W = 8,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic [ROW_W-1:0] row_idx,
    output logic [ROWS-1:0]  wl
);
    // One comparator per wordline.
    for (genvar r = 0; r < ROWS; r++) begin : g_wl
        assign wl[r] = (row_idx == ROW_W'(r));
    end
endmodule

// File: rtl/fold_col_select.sv
module fold_col_select #(
    parameter int DATA_W = 16,
    parameter int COL_W  = 3,
    localparam int LANES    = 1 << COL_W,
    localparam int ROW_BITS = DATA_W * LANES
) (
    input  logic [ROW_BITS-1:0] row_bits,
    input  logic [COL_W-1:0]    col,
    input  logic [DATA_W-1:0]   wr_word,
    output logic [DATA_W-1:0]   rd_word,
    output logic [ROW_BITS-1:0] merged_row
);
    // Bit i of column group c sits at physical column LANES*i + c.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic [LANES-1:0] taps;
        for (genvar c = 0; c < LANES; c++) begin : g_lane
            assign taps[c] = row_bits[LANES*i + c];
            assign merged_row[LANES*i + c] =
                (col == COL_W'(c)) ? wr_word[i] : row_bits[LANES*i + c];
        end
        // One LANES:1 selector per output bit.
        assign rd_word[i] = taps[col];
    end
endmodule

// File: rtl/fold_row_array.sv
module fold_row_array #(
    parameter int ROWS     = 256,
    parameter int ROW_BITS = 128
) (
    input  logic                clk,
    input  logic [ROWS-1:0]     wl,
    input  logic                wr_en,
    input  logic [ROW_BITS-1:0] wr_row,
    output logic [ROW_BITS-1:0] rd_row
);
    logic [ROW_BITS-1:0] cells [ROWS];

    // Wordline-gated read: the active row drives the shared bit bus.
    always_comb begin
        rd_row = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (wl[r]) rd_row = rd_row | cells[r];
        end
    end

    // Wordline-gated write of a full row (already merged).
    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (wr_en && wl[r]) cells[r] <= wr_row;
        end
    end
endmodule

// File: rtl/fold_mem_array.sv
module fold_mem_array
    import fold_mem_pkg::*;
#(
    parameter int ADDR_W = FM_ADDR_W,
    parameter int DATA_W = FM_DATA_W,
    parameter int COL_W  = FM_COL_W,
    localparam int ROW_W    = ADDR_W - COL_W,
    localparam int ROWS     = 1 << ROW_W,
    localparam int LANES    = 1 << COL_W,
    localparam int ROW_BITS = DATA_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [ROWS-1:0]   wordline
);
    logic [ROW_W-1:0]    row_idx;
    logic [COL_W-1:0]    col_idx;
    logic [ROW_BITS-1:0] row_rd;
    logic [ROW_BITS-1:0] row_wr;
    logic [DATA_W-1:0]   word_rd;

    assign row_idx = addr[ADDR_W-1:COL_W];
    assign col_idx = addr[COL_W-1:0];

    fold_row_decoder #(.ROW_W(ROW_W)) u_dec (
        .row_idx (row_idx),
        .wl      (wordline)
    );

    assert_one_wordline_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wordline) == 1);
    assert_wordline_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wordline[addr[ADDR_W-1:COL_W]]);

    fold_row_array #(.ROWS(ROWS), .ROW_BITS(ROW_BITS)) u_arr (
        .clk    (clk),
        .wl     (wordline),
        .wr_en  (wr_en),
        .wr_row (row_wr),
        .rd_row (row_rd)
    );

    fold_col_select #(.DATA_W(DATA_W), .COL_W(COL_W)) u_col (
        .row_bits   (row_rd),
        .col        (col_idx),
        .wr_word    (wr_data),
        .rd_word    (word_rd),
        .merged_row (row_wr)
    );

    // Read data register: captures the pre-write word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= word_rd;
    end

    assert_rd_zero_at_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rd_data == '0);
    assert_write_then_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && addr == $past(addr)) |=> rd_data == $past(wr_data, 2));
endmodule

// File: tb/fold_mem_array_tb.sv
module fold_mem_array_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [15:0] exp;
        bit          chk;
        string       req;
        logic [10:0] a;
    } item_t;

    logic        clk = 0;
    logic        rst_n;
    logic [10:0] addr;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic [255:0] wordline;

    logic [15:0] model [2048];
    item_t       q [$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fold_mem_array u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .wordline(wordline)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 40503) ^ 16'h5A5A);
    endfunction

    task automatic check(input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: applies one access and pushes the expected read result.
    task automatic access(input int a, input bit w, input logic [15:0] d,
                          input bit chk, input string req);
        item_t it;
        @(negedge clk);
        addr = 11'(a); wr_en = w; wr_data = d;
        it.exp = model[a]; it.chk = chk; it.req = req; it.a = 11'(a);
        if (w) model[a] = d;
        q.push_back(it);
        #1;
        if (chk) begin
            check("R3", 256'($countones(wordline)), 256'd1);
            check("R4", 256'(wordline[a >> 3]), 256'd1);
        end
    endtask

    // Monitor: pops one item per edge and compares.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                if (it.chk) check(it.req, 256'(rd_data), 256'(it.exp));
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; addr = '0; wr_en = 0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 256'(rd_data), 256'd0);   // R1: reset value
        rst_n = 1;

        // Fill every word with a distinct pattern (no read checks yet).
        for (int a = 0; a < 2048; a++) access(a, 1'b1, pat(a), 1'b0, "fill");

        // R2: read back all words, covering 0 and 2047.
        for (int a = 0; a < 2048; a++) access(a, 1'b0, 16'h0, 1'b1, "R2");
        access(0, 1'b0, 16'h0, 1'b1, "R2");
        access(2047, 1'b0, 16'h0, 1'b1, "R2");

        // R6: write returns previous contents.
        access(17*8 + 3, 1'b1, 16'hBEEF, 1'b1, "R6");
        // R7: all eight words of row 17.
        for (int c = 0; c < 8; c++) access(17*8 + c, 1'b0, 16'h0, 1'b1, "R7");
        // R8: neighbouring rows, same column group.
        access(16*8 + 3, 1'b0, 16'h0, 1'b1, "R8");
        access(18*8 + 3, 1'b0, 16'h0, 1'b1, "R8");

        // R5: write then read next cycle, several addresses and patterns.
        access(5, 1'b1, 16'hFFFF, 1'b1, "R6");
        access(5, 1'b0, 16'h0, 1'b1, "R5");
        access(2047, 1'b1, 16'h0000, 1'b1, "R6");
        access(2047, 1'b0, 16'h0, 1'b1, "R5");
        access(1024, 1'b1, 16'hA5C3, 1'b1, "R6");
        access(1024, 1'b0, 16'h0, 1'b1, "R5");

        // R6: two consecutive writes to one address.
        access(700, 1'b1, 16'h1234, 1'b1, "R6");
        access(700, 1'b1, 16'h5678, 1'b1, "R6");
        access(700, 1'b0, 16'h0, 1'b1, "R5");

        // R7: every column group of row 200 rewritten, then all re-read.
        for (int c = 0; c < 8; c++) access(200*8 + c, 1'b1, 16'(16'h0101 << c), 1'b1, "R7");
        for (int c = 0; c < 8; c++) access(200*8 + c, 1'b0, 16'h0, 1'b1, "R7");
        access(199*8 + 7, 1'b0, 16'h0, 1'b1, "R8");
        access(201*8, 1'b0, 16'h0, 1'b1, "R8");

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule